// File: doc/BRIEF.md
# Isochronous Timestamp Interval Calculator

This block keeps a free-running bus cycle timer that advances once per clock of the 24.576 MHz bus time base. The time value is split into three fields of mixed radix: a tick field that wraps at 3072, a cycle field that wraps at 8000, and a seconds field that wraps at 128. The block also watches a stream of received audio packets. For each packet it is given the 16-bit presentation timestamp from the packet's common isochronous header, a packet strobe and a flag that marks the packet as carrying samples.

The timestamp keeps the tick field in its low twelve bits and the low four cycle bits above them. A plain binary subtraction of two such values is therefore wrong. For every pair of successive accepted timestamps the block returns the true distance in bus ticks, handling both the tick borrow and the wrap of the truncated cycle field. Empty packets carry an all-ones timestamp. They are skipped and do not move the reference. A downstream rate estimator or buffer controller reads the interval strobe. At 44.1 kHz with eight samples per packet, the result sits near 4458 ticks.

Top module: `iso_stamp_interval`

## Requirements
- R1: During and right after reset, `cycle_time` is zero and `ivl_valid` is low.
- R2: The tick field `cycle_time[11:0]` increases by one on every clock and goes from 3071 back to 0.
- R3: The cycle field `cycle_time[24:12]` increases by one when the tick field wraps and goes from 7999 back to 0. The seconds field `cycle_time[31:25]` increases by one when the cycle field wraps, modulo 128.
- R4: A packet is accepted when `pkt_valid` and `pkt_data` are both high on a rising edge and `pkt_stamp` is not 0xFFFF. The interval for an accepted packet appears with a one-clock `ivl_valid` pulse in the clock after that edge.
- R5: The interval equals the difference of the cycle parts (`pkt_stamp[15:12]`) times 3072, plus the difference of the tick parts (`pkt_stamp[11:0]`). For example, 0x22BE followed by 0x3828 gives 4458.
- R6: When the new tick part is smaller than the reference tick part, one cycle is borrowed and 3072 is added to the tick difference.
- R7: The cycle difference is taken modulo 16, so a new stamp whose cycle part has wrapped past 15 still gives a short, correct interval, always below 49152.
- R8: After reset, `ivl_valid` stays low until two packets have been accepted. The first accepted packet only sets the reference.
- R9: A packet with stamp 0xFFFF, or with `pkt_data` low, causes no interval and leaves the reference unchanged. The next interval is measured from the last accepted stamp.
- R10: `ivl_ticks` holds its last value between `ivl_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus time base clock, one tick per edge |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | A packet header is presented this cycle |
| pkt_data | input | 1 | The presented packet carries samples |
| pkt_stamp | input | 16 | Presentation timestamp from the packet |
| ivl_valid | output | 1 | One-cycle strobe: a new interval is ready |
| ivl_ticks | output | 16 | Interval between accepted stamps, in ticks |
| cycle_time | output | 32 | Live timer: seconds, cycle and tick fields |

## Verification
On every clock the checker confirms several properties. The timer fields stay in range and step correctly, including both wraps. A strobe appears only after an accepted packet and never before two accepted packets. Ignored packets never produce a strobe. The interval value stays put between strobes and never exceeds the modulo-16 window. Only the bench scenarios can show the arithmetic itself. These cover the 4458-tick example, tick borrow, wrap of the four cycle bits, a zero interval, and keeping the reference across skipped packets. A small-radix second instance makes the cycle-field and seconds-field wraps reachable in a short run.

// File: rtl/iso_ts_pkg.sv
package iso_ts_pkg;
   localparam int DEF_TICK_W   = 12;
   localparam int DEF_TICK_MOD = 3072;
   localparam int DEF_CYC_W    = 13;
   localparam int DEF_CYC_MOD  = 8000;
   localparam int DEF_SEC_W    = 7;
   localparam int DEF_STAMP_W  = 16;

   // bits needed to hold the widest interval the stamp can express
   function automatic int ivl_bits(input int stamp_w, input int tick_w, input int tick_mod);
      return $clog2((2 ** (stamp_w - tick_w)) * tick_mod);
   endfunction
endpackage

// File: rtl/iso_cycle_timer.sv
module iso_cycle_timer #(
   parameter int TICK_W   = 12,
   parameter int TICK_MOD = 3072,
   parameter int CYC_W    = 13,
   parameter int CYC_MOD  = 8000,
   parameter int SEC_W    = 7
) (
   input  logic              clk,
   input  logic              rst,
   output logic [TICK_W-1:0] tick_o,
   output logic [CYC_W-1:0]  cyc_o,
   output logic [SEC_W-1:0]  sec_o
);
   localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_MOD - 1);
   localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(CYC_MOD - 1);

   logic tick_wrap, cyc_wrap;
   assign tick_wrap = (tick_o == TICK_LAST);
   assign cyc_wrap  = tick_wrap && (cyc_o == CYC_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         tick_o <= '0;
         cyc_o  <= '0;
         sec_o  <= '0;
      end else begin
         tick_o <= tick_wrap ? '0 : tick_o + 1'b1;
         if (tick_wrap) cyc_o <= cyc_wrap ? '0 : cyc_o + 1'b1;
         if (cyc_wrap)  sec_o <= sec_o + 1'b1;
      end
   end
endmodule

// File: rtl/iso_stamp_delta.sv
module iso_stamp_delta #(
   parameter int STAMP_W  = 16,
   parameter int TICK_W   = 12,
   parameter int TICK_MOD = 3072,
   parameter int IVL_W    = 16
) (
   input  logic [STAMP_W-1:0] new_i,
   input  logic [STAMP_W-1:0] ref_i,
   output logic [IVL_W-1:0]   ivl_o
);
   localparam int SC_W = STAMP_W - TICK_W;

   generate
      if (TICK_MOD == (2 ** TICK_W)) begin : g_binary
         // binary tick radix: the stamp is one plain counter
         logic [STAMP_W-1:0] raw;
         assign raw   = new_i - ref_i;
         assign ivl_o = IVL_W'(raw);
      end else begin : g_mixed
         logic [TICK_W-1:0] t_new, t_ref, t_fix;
         logic [SC_W-1:0]   c_new, c_ref, c_dif;
         logic [TICK_W:0]   t_dif;
         logic              borrow;

         assign t_new  = new_i[TICK_W-1:0];
         assign t_ref  = ref_i[TICK_W-1:0];
         assign c_new  = new_i[STAMP_W-1:TICK_W];
         assign c_ref  = ref_i[STAMP_W-1:TICK_W];
         assign t_dif  = {1'b0, t_new} - {1'b0, t_ref};
         assign borrow = t_dif[TICK_W];
         assign t_fix  = borrow ? (t_dif[TICK_W-1:0] + TICK_W'(TICK_MOD))
                                : t_dif[TICK_W-1:0];
         assign c_dif  = c_new - c_ref - SC_W'(borrow);
         assign ivl_o  = (IVL_W'(c_dif) * IVL_W'(TICK_MOD)) + IVL_W'(t_fix);
      end
   endgenerate
endmodule

// File: rtl/iso_interval_track.sv
module iso_interval_track #(
   parameter int STAMP_W = 16,
   parameter int IVL_W   = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               pkt_valid,
   input  logic               pkt_data,
   input  logic [STAMP_W-1:0] pkt_stamp,
   input  logic [IVL_W-1:0]   delta_i,
   output logic [STAMP_W-1:0] ref_o,
   output logic               ivl_valid,
   output logic [IVL_W-1:0]   ivl_ticks
);
   localparam logic [STAMP_W-1:0] EMPTY_STAMP = '1;

   logic accept, have_ref;
   assign accept = pkt_valid && pkt_data && (pkt_stamp != EMPTY_STAMP);

   always_ff @(posedge clk) begin
      if (rst) begin
         ref_o     <= '0;
         have_ref  <= 1'b0;
         ivl_valid <= 1'b0;
         ivl_ticks <= '0;
      end else begin
         ivl_valid <= 1'b0;
         if (accept) begin
            ref_o    <= pkt_stamp;
            have_ref <= 1'b1;
            if (have_ref) begin
               ivl_valid <= 1'b1;
               ivl_ticks <= delta_i;
            end
         end
      end
   end
endmodule

// File: rtl/iso_stamp_interval.sv
module iso_stamp_interval
   import iso_ts_pkg::*;
#(
   parameter int TICK_W   = DEF_TICK_W,
   parameter int TICK_MOD = DEF_TICK_MOD,
   parameter int CYC_W    = DEF_CYC_W,
   parameter int CYC_MOD  = DEF_CYC_MOD,
   parameter int SEC_W    = DEF_SEC_W,
   parameter int STAMP_W  = DEF_STAMP_W,
   parameter int IVL_W    = 16,
   parameter int TIME_W   = TICK_W + CYC_W + SEC_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               pkt_valid,
   input  logic               pkt_data,
   input  logic [STAMP_W-1:0] pkt_stamp,
   output logic               ivl_valid,
   output logic [IVL_W-1:0]   ivl_ticks,
   output logic [TIME_W-1:0]  cycle_time
);
   localparam int NEED_IVL_W = ivl_bits(STAMP_W, TICK_W, TICK_MOD);

   generate
      if (TICK_MOD < 2 || TICK_MOD > (2 ** TICK_W)) begin : g_bad_tick
         $error("TICK_MOD does not fit TICK_W");
      end
      if (CYC_MOD < 2 || CYC_MOD > (2 ** CYC_W)) begin : g_bad_cyc
         $error("CYC_MOD does not fit CYC_W");
      end
      if (STAMP_W <= TICK_W || STAMP_W > TICK_W + CYC_W) begin : g_bad_stamp
         $error("STAMP_W must hold the tick field plus 1..CYC_W cycle bits");
      end
      if (IVL_W < NEED_IVL_W) begin : g_bad_ivl
         $error("IVL_W too narrow for the widest interval");
      end
      if (TIME_W != TICK_W + CYC_W + SEC_W) begin : g_bad_time
         $error("TIME_W must equal the sum of the field widths");
      end
   endgenerate

   logic [TICK_W-1:0]  tick;
   logic [CYC_W-1:0]   cyc;
   logic [SEC_W-1:0]   sec;
   logic [STAMP_W-1:0] ref_stamp;
   logic [IVL_W-1:0]   delta;

   iso_cycle_timer #(
      .TICK_W(TICK_W), .TICK_MOD(TICK_MOD),
      .CYC_W(CYC_W), .CYC_MOD(CYC_MOD), .SEC_W(SEC_W)
   ) timer_i (
      .clk(clk), .rst(rst), .tick_o(tick), .cyc_o(cyc), .sec_o(sec)
   );

   assign cycle_time = {sec, cyc, tick};

   iso_stamp_delta #(
      .STAMP_W(STAMP_W), .TICK_W(TICK_W), .TICK_MOD(TICK_MOD), .IVL_W(IVL_W)
   ) delta_i (
      .new_i(pkt_stamp), .ref_i(ref_stamp), .ivl_o(delta)
   );

   iso_interval_track #(
      .STAMP_W(STAMP_W), .IVL_W(IVL_W)
   ) track_i (
      .clk(clk), .rst(rst),
      .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_stamp(pkt_stamp),
      .delta_i(delta), .ref_o(ref_stamp),
      .ivl_valid(ivl_valid), .ivl_ticks(ivl_ticks)
   );
endmodule

// File: rtl/iso_stamp_interval_chk.sv
module iso_stamp_interval_chk #(
   parameter int TICK_W   = 12,
   parameter int TICK_MOD = 3072,
   parameter int CYC_W    = 13,
   parameter int CYC_MOD  = 8000,
   parameter int SEC_W    = 7,
   parameter int STAMP_W  = 16,
   parameter int IVL_W    = 16,
   parameter int TIME_W   = TICK_W + CYC_W + SEC_W
) (
   input logic               clk,
   input logic               rst,
   input logic               pkt_valid,
   input logic               pkt_data,
   input logic [STAMP_W-1:0] pkt_stamp,
   input logic               ivl_valid,
   input logic [IVL_W-1:0]   ivl_ticks,
   input logic [TIME_W-1:0]  cycle_time
);
   localparam int SC_W = STAMP_W - TICK_W;
   localparam longint IVL_LIMIT = (64'(1) << SC_W) * TICK_MOD;

   logic [TICK_W-1:0] c_tick;
   logic [CYC_W-1:0]  c_cyc;
   logic [SEC_W-1:0]  c_sec;
   logic              c_take, c_skip;
   logic [1:0]        c_seen;

   assign c_tick = cycle_time[TICK_W-1:0];
   assign c_cyc  = cycle_time[TICK_W+CYC_W-1:TICK_W];
   assign c_sec  = cycle_time[TIME_W-1:TICK_W+CYC_W];
   assign c_take = pkt_valid && pkt_data && (pkt_stamp != '1);
   assign c_skip = pkt_valid && !c_take;

   always_ff @(posedge clk) begin
      if (rst) c_seen <= '0;
      else if (c_take && c_seen != 2'd2) c_seen <= c_seen + 1'b1;
   end

   a_r1_reset_quiet: assert property (@(posedge clk)
      $past(rst) |-> (cycle_time == '0 && !ivl_valid));

   a_r2_tick_range: assert property (@(posedge clk) disable iff (rst)
      longint'(c_tick) < TICK_MOD);

   a_r2_tick_step: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (c_tick == (($past(c_tick) == TICK_W'(TICK_MOD-1)) ? '0
                                  : TICK_W'($past(c_tick) + 1'b1))));

   a_r3_cyc_range: assert property (@(posedge clk) disable iff (rst)
      longint'(c_cyc) < CYC_MOD);

   a_r3_cyc_step: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(c_tick) == TICK_W'(TICK_MOD-1)) |->
         (c_cyc == (($past(c_cyc) == CYC_W'(CYC_MOD-1)) ? '0
                    : CYC_W'($past(c_cyc) + 1'b1))));

   a_r3_sec_hold: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !($past(c_tick) == TICK_W'(TICK_MOD-1) &&
                        $past(c_cyc) == CYC_W'(CYC_MOD-1))) |-> $stable(c_sec));

   a_r4_strobe_follows_take: assert property (@(posedge clk) disable iff (rst)
      ivl_valid |-> $past(c_take));

   a_r7_ivl_bound: assert property (@(posedge clk) disable iff (rst)
      ivl_valid |-> longint'(ivl_ticks) < IVL_LIMIT);

   a_r8_two_stamps: assert property (@(posedge clk) disable iff (rst)
      ivl_valid |-> c_seen == 2'd2);

   a_r9_skip_silent: assert property (@(posedge clk) disable iff (rst)
      c_skip |=> !ivl_valid);

   a_r10_ivl_hold: assert property (@(posedge clk) disable iff (rst)
      !ivl_valid |-> $stable(ivl_ticks));
endmodule

bind iso_stamp_interval iso_stamp_interval_chk #(
   .TICK_W(TICK_W), .TICK_MOD(TICK_MOD), .CYC_W(CYC_W), .CYC_MOD(CYC_MOD),
   .SEC_W(SEC_W), .STAMP_W(STAMP_W), .IVL_W(IVL_W), .TIME_W(TIME_W)
) chk_i (
   .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
   .pkt_stamp(pkt_stamp), .ivl_valid(ivl_valid), .ivl_ticks(ivl_ticks),
   .cycle_time(cycle_time)
);

// File: tb/iso_stamp_interval_tb_top.sv
module iso_stamp_interval_tb_top;
   localparam int TM  = 3072;
   localparam int WIN = 16 * TM;
   localparam int SM_TM = 4;
   localparam int SM_CM = 5;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        pkt_valid = 1'b0;
   logic        pkt_data  = 1'b0;
   logic [15:0] pkt_stamp = '0;
   logic        ivl_valid;
   logic [15:0] ivl_ticks;
   logic [31:0] cycle_time;
   logic        sm_ivl_valid;
   logic [15:0] sm_ivl_ticks;
   logic [31:0] sm_time;

   int n_run = 0, n_fail = 0, n_strobe = 0;
   bit done = 1'b0;
   int exp_q[$];
   string tag_q[$];
   bit have_ref = 1'b0;
   logic [15:0] ref_s = '0;
   int last_exp = 0;

   always #4 clk = ~clk;

   iso_stamp_interval dut_i (
      .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
      .pkt_stamp(pkt_stamp), .ivl_valid(ivl_valid), .ivl_ticks(ivl_ticks),
      .cycle_time(cycle_time)
   );

   // small radix copy makes cycle and seconds wraps reachable
   iso_stamp_interval #(.TICK_MOD(SM_TM), .CYC_MOD(SM_CM)) dut_small_i (
      .clk(clk), .rst(rst), .pkt_valid(1'b0), .pkt_data(1'b0),
      .pkt_stamp(16'h0000), .ivl_valid(sm_ivl_valid), .ivl_ticks(sm_ivl_ticks),
      .cycle_time(sm_time)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int lin(input logic [15:0] s);
      return int'(s[15:12]) * TM + int'(s[11:0]);
   endfunction

   // driver: presents one packet for one clock, pushes the expected interval
   task automatic send(input logic [15:0] s, input bit data, input string tag);
      @(negedge clk);
      pkt_valid = 1'b1;
      pkt_data  = data;
      pkt_stamp = s;
      if (data && s != 16'hFFFF) begin
         if (have_ref) begin
            exp_q.push_back((lin(s) - lin(ref_s) + WIN) % WIN);
            tag_q.push_back(tag);
         end
         have_ref = 1'b1;
         ref_s = s;
      end
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      pkt_valid = 1'b0;
      pkt_data  = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops expected intervals as strobes appear
   initial begin
      forever begin
         @(negedge clk);
         if (!rst && ivl_valid) begin
            n_strobe++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R8/R9 unexpected strobe", ivl_ticks, -1);
            end else begin
               automatic int e = exp_q.pop_front();
               automatic string t = tag_q.pop_front();
               last_exp = e;
               check(ivl_ticks == 16'(e), t, ivl_ticks, e);
            end
         end
      end
   end

   // timer monitor for both instances (R2, R3)
   initial begin
      automatic int t = 0, c = 0, s = 0, st = 0, sc = 0, ss = 0;
      forever begin
         @(negedge clk);
         if (rst) begin
            t = 0; c = 0; s = 0; st = 0; sc = 0; ss = 0;
         end else begin
            if (t == TM - 1) begin
               t = 0;
               if (c == 7999) begin c = 0; s = (s + 1) % 128; end else c++;
            end else t++;
            if (st == SM_TM - 1) begin
               st = 0;
               if (sc == SM_CM - 1) begin sc = 0; ss = (ss + 1) % 128; end else sc++;
            end else st++;
            check(cycle_time == {7'(s), 13'(c), 12'(t)}, "R2/R3 default timer",
                  cycle_time, {7'(s), 13'(c), 12'(t)});
            check(sm_time == {7'(ss), 13'(sc), 12'(st)}, "R3 small timer wraps",
                  sm_time, {7'(ss), 13'(sc), 12'(st)});
         end
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         check(1'b0, "watchdog", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      check(cycle_time == 32'd0, "R1 timer in reset", cycle_time, 0);
      check(!ivl_valid, "R1 strobe in reset", ivl_valid, 0);
      rst = 1'b0;
      @(negedge clk);
      check(!ivl_valid, "R1 strobe after reset", ivl_valid, 0);

      send(16'h22BE, 1'b1, "R4");
      idle(3);
      check(n_strobe == 0, "R8 first stamp only sets reference", n_strobe, 0);
      send(16'h3828, 1'b1, "R5 example 4458");
      idle(3);
      check(last_exp == 4458 && ivl_ticks == 16'd4458, "R5 example value", ivl_ticks, 4458);
      check(ivl_ticks == 16'd4458, "R10 held after strobe", ivl_ticks, 4458);

      send(16'hFFFF, 1'b1, "R9 empty");
      send(16'h4000, 1'b0, "R9 no data");
      idle(2);
      check(n_strobe == 1, "R9 skipped packets give no strobe", n_strobe, 1);
      check(ivl_ticks == 16'd4458, "R10 held across skips", ivl_ticks, 4458);
      send(16'h5192, 1'b1, "R9 reference kept");
      send(16'h6010, 1'b1, "R6 tick borrow");
      send(16'hF200, 1'b1, "R5 forward");
      send(16'h0100, 1'b1, "R7 cycle bits wrap");
      send(16'h0100, 1'b1, "R5 zero interval");
      send(16'hE000, 1'b1, "R7 long wrap");
      send(16'h2000, 1'b1, "R7 wrap 4 cycles");
      send(16'h2BFF, 1'b1, "R5 max tick");
      send(16'h3000, 1'b1, "R6 borrow to one tick");
      idle(4);
      check(ivl_ticks == 16'(last_exp), "R10 held value", ivl_ticks, last_exp);

      idle(7000);
      check(exp_q.size() == 0, "R4 all intervals seen", exp_q.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule